// File: doc/BRIEF.md
# Dual-Clock FIFO with Read Rewind

This block is a first-in first-out buffer for 9-bit words. A producer writes on its own free-running clock and a consumer reads on another. The two clocks may come from one source or be unrelated. Each side has an active-low enable. A word is stored on every write-clock edge while the write enable is low. A word moves into the registered read output on every read-clock edge while the read enable is low. Both sides may act on the same edge.

Each pointer crosses into the other clock domain as a Gray code through a chain of synchronizer flops. Full, half full and almost full are derived on the write side. Empty and almost empty are derived on the read side. The almost-empty and almost-full margins are programmable: each margin has a load strobe on the clock of the side that uses it, and a master reset restores the default margins.

A rewind input sends the read pointer back to the first word stored since reset, so that the same data can be read out again. The rewind is allowed only while both enables are inactive, and only while no more than one depth's worth of words has been written since reset.

Top module: `dualclk_rt_fifo`

## Requirements
- R1: With `mrst_n` low at a rising edge of both clocks, the block clears both pointers and the read output to zero and reloads the default margins. After reset, `empty` = 1, `full` = 0, `half_full` = 0, `almost_full` = 0, and `almost_empty` = 1 when the default almost-empty margin is 0 or more.
- R2: A write-clock edge with `wen_n` = 0 and `full` = 0 stores `wdata`. Words are delivered on `rdata` in the order they were written.
- R3: A read-clock edge with `ren_n` = 0 and `empty` = 0 loads the oldest unread word into `rdata`. At any other edge, `rdata` keeps its value.
- R4: `empty` is 1 exactly when the stored count is 0, and `full` is 1 exactly when the count equals the depth. Once the opposite side goes idle, both flags settle within three cycles of its clock.
- R5: `half_full` is 1 exactly when the stored count is greater than half the depth.
- R6: `almost_empty` is 1 when the count is less than or equal to the almost-empty margin. The margin is loaded from `ae_off` on a read-clock edge with `ae_ld` = 1.
- R7: `almost_full` is 1 when the count is greater than or equal to the depth minus the almost-full margin. The margin is loaded from `af_off` on a write-clock edge with `af_ld` = 1.
- R8: A write while `full` = 1 changes neither the stored data nor the count. A read while `empty` = 1 changes neither `rdata` nor the count.
- R9: A read-clock edge with `rtx_n` = 0 and `ren_n` = 1 sets the read pointer back to zero. Following reads return again the words stored since reset, starting from the first one. This assumes `wen_n` = 1 and no more than one depth of writes since reset.
- R10: A write and a read on the same edge are both performed. The count is unchanged and the data order is kept.
- R11: Each Gray-coded pointer changes in at most one bit per edge of its own clock. The one exception is the rewind of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, sampled by both clocks |
| wen_n | input | 1 | Write enable, active low |
| wdata | input | DATA_W | Word to store |
| ren_n | input | 1 | Read enable, active low |
| rtx_n | input | 1 | Rewind request, active low (read clock) |
| rdata | output | DATA_W | Registered read word |
| af_ld | input | 1 | Load strobe for the almost-full margin (write clock) |
| af_off | input | ADDR_W | Almost-full margin value |
| ae_ld | input | 1 | Load strobe for the almost-empty margin (read clock) |
| ae_off | input | ADDR_W | Almost-empty margin value |
| empty | output | 1 | No word available (read side) |
| full | output | 1 | No space left (write side) |
| half_full | output | 1 | More than half the depth occupied (write side) |
| almost_empty | output | 1 | Count at or below the almost-empty margin |
| almost_full | output | 1 | Count at or above depth minus the almost-full margin |

## Verification
The bench builds the block with `ADDR_W` = 3, which gives eight words, and with both default margins set to 1. Both clocks are driven from one shared source. At this size every fill level from zero to full can be visited. Every margin value from 0 to 7 can be swept on both flags, filling and draining at each setting, and the pointers wrap within a few dozen cycles. A shared clock fixes the synchronizer delay at a known number of edges, so flag values can be predicted from the arithmetic count alone.

// File: rtl/dcf_pkg.sv
// Package dcf_pkg
// Holds the project-wide defaults shared by the dual-clock FIFO modules.
// Assumes nothing beyond a SystemVerilog-2017 compiler.
package dcf_pkg;
    localparam int unsigned WORD_W      = 9;  // data word width
    localparam int unsigned SYNC_DEPTH  = 2;  // flops per pointer synchronizer
endpackage

// File: rtl/dcf_gray_sync.sv
// Module dcf_gray_sync
// Brings a Gray-coded pointer into the local clock domain through a chain
// of STAGES flops, then converts the last stage back to binary.
// Assumes the source changes at most one bit per source-clock cycle.
module dcf_gray_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = dcf_pkg::SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the foreign Gray value through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= gray_in;
            for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
        end
    end

    // Convert the settled Gray value to binary, MSB first.
    always_comb begin
        logic [W-1:0] acc;
        acc[W-1] = stage_q[STAGES-1][W-1];
        for (int b = int'(W) - 2; b >= 0; b--) acc[b] = acc[b+1] ^ stage_q[STAGES-1][b];
        bin_out = acc;
    end
endmodule

// File: rtl/dcf_wr_ctrl.sv
// Module dcf_wr_ctrl
// Write-side control: advances the write pointer, blocks writes when full,
// and derives full, half full and almost full from the synchronized read
// pointer. Holds the almost-full margin register.
// Assumes rptr_sync is already in the write clock domain.
module dcf_wr_ctrl #(
    parameter int unsigned AW     = 12,
    parameter int unsigned DEF_AF = 8
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wen_n,
    input  logic          af_ld,
    input  logic [AW-1:0] af_off,
    input  logic [AW:0]   rptr_sync,
    output logic [AW:0]   wptr,
    output logic [AW:0]   wgray,
    output logic          wr_fire,
    output logic          full,
    output logic          half_full,
    output logic          almost_full
);
    localparam int unsigned PW    = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1) << AW;

    logic [PW-1:0] wptr_q;
    logic [PW-1:0] fill;
    logic [AW-1:0] af_q;

    // Occupancy as seen from the write side.
    assign fill        = wptr_q - rptr_sync;
    assign full        = (fill == DEPTH_P);
    assign half_full   = (fill > (DEPTH_P >> 1));
    assign almost_full = (fill >= (DEPTH_P - {1'b0, af_q}));
    assign wr_fire     = !wen_n && !full;
    assign wptr        = wptr_q;
    assign wgray       = wptr_q ^ (wptr_q >> 1);

    // Advance the write pointer on each accepted write.
    always_ff @(posedge wclk) begin
        if (!rst_n)       wptr_q <= '0;
        else if (wr_fire) wptr_q <= wptr_q + 1'b1;
    end

    // Hold the almost-full margin; reset restores the default.
    always_ff @(posedge wclk) begin
        if (!rst_n)     af_q <= AW'(DEF_AF);
        else if (af_ld) af_q <= af_off;
    end
endmodule

// File: rtl/dcf_rd_ctrl.sv
// Module dcf_rd_ctrl
// Read-side control: advances or rewinds the read pointer, blocks reads when
// empty, and derives empty and almost empty from the synchronized write
// pointer. Holds the almost-empty margin register.
// Assumes wptr_sync is already in the read clock domain and that a rewind
// is requested only while the write side is idle.
module dcf_rd_ctrl #(
    parameter int unsigned AW     = 12,
    parameter int unsigned DEF_AE = 8
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          ren_n,
    input  logic          rtx_n,
    input  logic          ae_ld,
    input  logic [AW-1:0] ae_off,
    input  logic [AW:0]   wptr_sync,
    output logic [AW:0]   rptr,
    output logic [AW:0]   rgray,
    output logic          rd_fire,
    output logic          empty,
    output logic          almost_empty
);
    localparam int unsigned PW = AW + 1;

    logic [PW-1:0] rptr_q;
    logic [PW-1:0] level;
    logic [AW-1:0] ae_q;
    logic          rewind;

    // Occupancy as seen from the read side.
    assign level        = wptr_sync - rptr_q;
    assign empty        = (level == '0);
    assign almost_empty = (level <= {1'b0, ae_q});
    assign rd_fire      = !ren_n && !empty;
    assign rewind       = ren_n && !rtx_n;
    assign rptr         = rptr_q;
    assign rgray        = rptr_q ^ (rptr_q >> 1);

    // Step the read pointer, or send it back to the first stored word.
    always_ff @(posedge rclk) begin
        if (!rst_n)       rptr_q <= '0;
        else if (rewind)  rptr_q <= '0;
        else if (rd_fire) rptr_q <= rptr_q + 1'b1;
    end

    // Hold the almost-empty margin; reset restores the default.
    always_ff @(posedge rclk) begin
        if (!rst_n)     ae_q <= AW'(DEF_AE);
        else if (ae_ld) ae_q <= ae_off;
    end
endmodule

// File: rtl/dcf_ram.sv
// Module dcf_ram
// Two-port word store: write port on wclk, registered read port on rclk.
// Assumes the controllers never read the location being written.
module dcf_ram #(
    parameter int unsigned DW = dcf_pkg::WORD_W,
    parameter int unsigned AW = 12
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store an accepted word.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Move the addressed word into the output register on an accepted read.
    always_ff @(posedge rclk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/dualclk_rt_fifo.sv
// Module dualclk_rt_fifo
// Dual-clock FIFO with read rewind and programmable almost flags.
// Wires the write controller, read controller, two pointer synchronizers
// and the word store together.
// Assumes mrst_n is held low for at least three edges of the slower clock.
module dualclk_rt_fifo #(
    parameter int unsigned DATA_W = dcf_pkg::WORD_W,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DEF_AE = 8,
    parameter int unsigned DEF_AF = 8
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrst_n,
    input  logic              wen_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ren_n,
    input  logic              rtx_n,
    output logic [DATA_W-1:0] rdata,
    input  logic              af_ld,
    input  logic [ADDR_W-1:0] af_off,
    input  logic              ae_ld,
    input  logic [ADDR_W-1:0] ae_off,
    output logic              empty,
    output logic              full,
    output logic              half_full,
    output logic              almost_empty,
    output logic              almost_full
);
    localparam int unsigned PW = ADDR_W + 1;

    logic [PW-1:0] wptr_bin, rptr_bin, wgray, rgray;
    logic [PW-1:0] wptr_in_rd, rptr_in_wr;
    logic          wr_fire, rd_fire;

    dcf_wr_ctrl #(.AW(ADDR_W), .DEF_AF(DEF_AF)) u_wr (
        .wclk(wclk), .rst_n(mrst_n), .wen_n(wen_n),
        .af_ld(af_ld), .af_off(af_off), .rptr_sync(rptr_in_wr),
        .wptr(wptr_bin), .wgray(wgray), .wr_fire(wr_fire),
        .full(full), .half_full(half_full), .almost_full(almost_full)
    );

    dcf_rd_ctrl #(.AW(ADDR_W), .DEF_AE(DEF_AE)) u_rd (
        .rclk(rclk), .rst_n(mrst_n), .ren_n(ren_n), .rtx_n(rtx_n),
        .ae_ld(ae_ld), .ae_off(ae_off), .wptr_sync(wptr_in_rd),
        .rptr(rptr_bin), .rgray(rgray), .rd_fire(rd_fire),
        .empty(empty), .almost_empty(almost_empty)
    );

    dcf_gray_sync #(.W(PW)) u_w2r (
        .clk(rclk), .rst_n(mrst_n), .gray_in(wgray), .bin_out(wptr_in_rd)
    );

    dcf_gray_sync #(.W(PW)) u_r2w (
        .clk(wclk), .rst_n(mrst_n), .gray_in(rgray), .bin_out(rptr_in_wr)
    );

    dcf_ram #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .wclk(wclk), .we(wr_fire), .waddr(wptr_bin[ADDR_W-1:0]), .wdata(wdata),
        .rclk(rclk), .rst_n(mrst_n), .re(rd_fire), .raddr(rptr_bin[ADDR_W-1:0]),
        .rdata(rdata)
    );
endmodule

// File: rtl/dcf_chk.sv
// Module dcf_chk
// Property checker for dualclk_rt_fifo, attached by bind below.
// Assumes mrst_n is low at the first edges of both clocks.
module dcf_chk #(
    parameter int unsigned AW = 12
) (
    input logic        wclk,
    input logic        rclk,
    input logic        mrst_n,
    input logic        wen_n,
    input logic        ren_n,
    input logic        rtx_n,
    input logic        full,
    input logic        empty,
    input logic        half_full,
    input logic        almost_full,
    input logic        almost_empty,
    input logic [AW:0] wptr,
    input logic [AW:0] rptr,
    input logic [AW:0] wgray,
    input logic [AW:0] rgray
);
    // R2
    write_step_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        (!wen_n && !full) |=> (wptr == $past(wptr) + 1'b1));

    // R8
    no_overflow_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        (full && !wen_n) |=> $stable(wptr));

    // R8
    no_underflow_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
        (empty && !ren_n) |=> $stable(rptr));

    // R9
    rewind_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
        (ren_n && !rtx_n) |=> (rptr == '0));

    // R5
    full_implies_high_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        full |-> (half_full && almost_full));

    // R6
    empty_implies_low_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
        empty |-> almost_empty);

    // R11
    wgray_step_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R11
    rgray_step_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
        ($past(rtx_n) || !$past(ren_n)) |-> ($countones(rgray ^ $past(rgray)) <= 1));
endmodule

bind dualclk_rt_fifo dcf_chk #(.AW(ADDR_W)) u_chk (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n),
    .wen_n(wen_n), .ren_n(ren_n), .rtx_n(rtx_n),
    .full(full), .empty(empty), .half_full(half_full),
    .almost_full(almost_full), .almost_empty(almost_empty),
    .wptr(wptr_bin), .rptr(rptr_bin), .wgray(wgray), .rgray(rgray)
);

// File: tb/dualclk_rt_fifo_tb_top.sv
`timescale 1ns/1ps
// Bench for dualclk_rt_fifo: eight-word build, shared 200 MHz clock.
module dualclk_rt_fifo_tb_top;
    localparam int AW  = 3;
    localparam int DEP = 1 << AW;

    logic clk = 1'b0;
    logic mrst_n = 1'b0;
    logic wen_n = 1'b1, ren_n = 1'b1, rtx_n = 1'b1;
    logic [8:0] wdata = '0;
    logic [8:0] rdata;
    logic af_ld = 1'b0, ae_ld = 1'b0;
    logic [AW-1:0] af_off = '0, ae_off = '0;
    logic empty, full, half_full, almost_empty, almost_full;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dualclk_rt_fifo #(.DATA_W(9), .ADDR_W(AW), .DEF_AE(1), .DEF_AF(1)) dut_i (
        .wclk(clk), .rclk(clk), .mrst_n(mrst_n),
        .wen_n(wen_n), .wdata(wdata), .ren_n(ren_n), .rtx_n(rtx_n), .rdata(rdata),
        .af_ld(af_ld), .af_off(af_off), .ae_ld(ae_ld), .ae_off(ae_off),
        .empty(empty), .full(full), .half_full(half_full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) mrst_n = 1'b0;
        idle(4);
        mrst_n = 1'b1;
    endtask

    task automatic load_margins(input int ae, input int af);
        @(negedge clk) begin ae_ld = 1'b1; ae_off = AW'(ae); af_ld = 1'b1; af_off = AW'(af); end
        @(negedge clk) begin ae_ld = 1'b0; af_ld = 1'b0; end
    endtask

    task automatic push(input int v);
        @(negedge clk) begin wen_n = 1'b0; wdata = 9'(v); end
        @(negedge clk) wen_n = 1'b1;
    endtask

    task automatic pop(output int v);
        @(negedge clk) ren_n = 1'b0;
        @(negedge clk) ren_n = 1'b1;
        v = int'(rdata);
    endtask

    // Flags expected for a settled count n with margins ae and af.
    task automatic check_level(input int n, input int ae, input int af);
        chk("R4 empty", int'(empty), int'(n == 0));
        chk("R4 full", int'(full), int'(n == DEP));
        chk("R5 half_full", int'(half_full), int'(n > DEP / 2));
        chk("R6 almost_empty", int'(almost_empty), int'(n <= ae));
        chk("R7 almost_full", int'(almost_full), int'(n >= DEP - af));
    endtask

    initial begin
        int v;
        int last;
        idle(4);
        mrst_n = 1'b1;
        idle(3);
        // R1: reset state with default margins of 1
        check_level(0, 1, 1);
        chk("R1 rdata", int'(rdata), 0);

        // Sweep every margin value, filling and draining at each level.
        for (int off = 0; off < DEP; off++) begin
            int ae = off;
            int af = DEP - 1 - off;
            do_reset();
            load_margins(ae, af);
            idle(3);
            check_level(0, ae, af);
            for (int n = 1; n <= DEP; n++) begin
                push(off * 16 + n);
                idle(3);
                check_level(n, ae, af);
            end
            // R8: write while full is dropped
            push(9'h1FF);
            idle(3);
            check_level(DEP, ae, af);
            for (int n = DEP; n >= 1; n--) begin
                pop(v);
                chk("R2 R3 order", v, off * 16 + (DEP - n + 1));
                idle(3);
                check_level(n - 1, ae, af);
            end
            // R8: read while empty leaves rdata and count alone
            last = int'(rdata);
            pop(v);
            chk("R8 rdata held on empty", v, last);
            idle(3);
            check_level(0, ae, af);
        end

        // R9: rewind replays from the first stored word
        do_reset();
        load_margins(0, 0);
        for (int i = 0; i < 5; i++) push(100 + i);
        idle(3);
        for (int i = 0; i < 5; i++) begin
            pop(v);
            chk("R9 first pass", v, 100 + i);
        end
        idle(3);
        check_level(0, 0, 0);
        @(negedge clk) rtx_n = 1'b0;
        @(negedge clk) rtx_n = 1'b1;
        idle(3);
        check_level(5, 0, 0);
        for (int i = 0; i < 5; i++) begin
            pop(v);
            chk("R9 replay", v, 100 + i);
        end
        idle(3);
        check_level(0, 0, 0);

        // R10: simultaneous read and write keep count and order
        do_reset();
        load_margins(0, 0);
        for (int i = 0; i < 3; i++) push(200 + i);
        idle(3);
        @(negedge clk) begin wen_n = 1'b0; ren_n = 1'b0; wdata = 9'd210; end
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R10 streamed word", int'(rdata), (i < 3) ? 200 + i : 210 + i - 3);
            wdata = 9'(211 + i);
        end
        wen_n = 1'b1;
        ren_n = 1'b1;
        idle(3);
        check_level(3, 0, 0);
        for (int i = 0; i < 3; i++) begin
            pop(v);
            chk("R10 tail", v, 217 + i);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule